// File: doc/BRIEF.md
# Multiplier with Selectable Product Scaling

This block is the multiply unit of a fixed-point datapath. It holds a 16-bit operand register and a 32-bit product register and forms a full 32-bit product of two 16-bit values in a single clock. Each operation arrives as a 3-bit opcode with a 16-bit data word, qualified by a valid strobe. The unit can multiply signed or unsigned, square the incoming word, or multiply by a short immediate. It can also clear the product, write the product's upper half directly, and set the output scaling mode.

The product register drives a scaler whose 2-bit mode is held in the block. The scaler passes the product through, shifts it left by one or four places, or shifts it right by six places with sign extension. Downstream arithmetic or the store path takes the scaled value. The stored product itself is never changed by the scaler. Software can save the two product halves and later rebuild the register. To do so it loads the saved low half into the operand register, multiplies by immediate 1, and then writes the saved high half.

Top module: `mps_top`

## Requirements
- R1: After reset, the operand register, the product register and the scale mode all read zero.
- R2: Opcode 1 loads opData into the operand register. The product register is unchanged.
- R3: Opcode 2 writes the signed two's-complement product of the operand register and opData into the product register at the next clock edge.
- R4: Opcode 3 writes the unsigned product of the operand register and opData into the product register.
- R5: Opcode 4 writes the signed square of opData into the product register. The operand register is unchanged.
- R6: Opcode 5 sign-extends opData[12:0] to 16 bits and multiplies it, signed, by the operand register. opData[15:13] are ignored, so an immediate of zero clears the product register.
- R7: Opcode 6 writes opData into product bits [31:16] and keeps bits [15:0].
- R8: Opcode 7 clears the product register.
- R9: Opcode 0 loads the scale mode from opData[1:0]. No other opcode changes the mode.
- R10: With scale mode 00, prodScaled equals the product register. With mode 01, prodScaled is the product shifted left by 1 with zero fill.
- R11: With scale mode 10, prodScaled is the product shifted left by 4 with zero fill.
- R12: With scale mode 11, prodScaled is the product shifted right by 6 with its sign bit copied into the vacated upper bits.
- R13: Scaling never alters the product register. While opValid is low, all held state keeps its value whatever opCode and opData carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Qualifies opCode and opData for this cycle |
| opCode | input | 3 | Operation select (0 mode, 1 operand load, 2 signed, 3 unsigned, 4 square, 5 immediate, 6 high-half load, 7 clear) |
| opData | input | 16 | Data word for the operation |
| tmpReg | output | 16 | Operand register |
| prodReg | output | 32 | Product register, unscaled |
| scaleMode | output | 2 | Current scale mode |
| prodScaled | output | 32 | Product after the mode-selected scaler |

## Verification
The properties assume that opValid, opCode and opData are synchronous to clk and settled before each rising edge. They also assume that opCode is a defined value whenever opValid is high. The bench changes every input only on the falling edge and returns opValid low between operations. During held cycles it leaves an active-looking opcode and data on the bus, so the hold checks observe real stimulus rather than idle values.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [2:0] {
    OP_MODE  = 3'd0,
    OP_LDTMP = 3'd1,
    OP_MULS  = 3'd2,
    OP_MULU  = 3'd3,
    OP_SQR   = 3'd4,
    OP_MULI  = 3'd5,
    OP_LDHI  = 3'd6,
    OP_CLR   = 3'd7
  } opSel_e;

  typedef struct packed {
    logic tmpLoad;
    logic prodLoad;
    logic prodHiLoad;
    logic prodClear;
    logic modeLoad;
    logic useUnsigned;
    logic useSquare;
    logic useImm;
  } mulStrobe_t;
endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import mps_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  output mulStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (opValid) begin
      case (opSel_e'(opCode))
        OP_MODE:  strobe.modeLoad = 1'b1;
        OP_LDTMP: strobe.tmpLoad = 1'b1;
        OP_MULS:  strobe.prodLoad = 1'b1;
        OP_MULU: begin
          strobe.prodLoad = 1'b1;
          strobe.useUnsigned = 1'b1;
        end
        OP_SQR: begin
          strobe.prodLoad = 1'b1;
          strobe.useSquare = 1'b1;
        end
        OP_MULI: begin
          strobe.prodLoad = 1'b1;
          strobe.useImm = 1'b1;
        end
        OP_LDHI:  strobe.prodHiLoad = 1'b1;
        OP_CLR:   strobe.prodClear = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/mps_scaler.sv
module mps_scaler #(
  parameter int PROD_W = 32,
  parameter int SH_ONE = 1,
  parameter int SH_FOUR = 4,
  parameter int SH_RIGHT = 6
) (
  input  logic [PROD_W-1:0] prodIn,
  input  logic [1:0]        mode,
  output logic [PROD_W-1:0] prodOut
);
  always_comb begin
    case (mode)
      2'b00:   prodOut = prodIn;
      2'b01:   prodOut = prodIn << SH_ONE;
      2'b10:   prodOut = prodIn << SH_FOUR;
      default: prodOut = PROD_W'($signed(prodIn) >>> SH_RIGHT);
    endcase
  end
endmodule

// File: rtl/mps_datapath.sv
module mps_datapath
  import mps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W = 13,
  parameter int SH_ONE = 1,
  parameter int SH_FOUR = 4,
  parameter int SH_RIGHT = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mulStrobe_t            strobe,
  input  logic [DATA_W-1:0]     opData,
  output logic [DATA_W-1:0]     tmpQ,
  output logic [2*DATA_W-1:0]   prodQ,
  output logic [1:0]            modeQ,
  output logic [2*DATA_W-1:0]   prodScaled
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0]      immExt;
  logic [DATA_W-1:0]      opA;
  logic [DATA_W-1:0]      opB;
  logic [EXT_W-1:0]       extA;
  logic [EXT_W-1:0]       extB;
  logic signed [2*EXT_W-1:0] fullP;
  logic [PROD_W-1:0]      prodNext;

  assign immExt = {{(DATA_W-IMM_W){opData[IMM_W-1]}}, opData[IMM_W-1:0]};
  assign opA = strobe.useSquare ? opData : tmpQ;
  assign opB = strobe.useImm ? immExt : opData;
  assign extA = {~strobe.useUnsigned & opA[DATA_W-1], opA};
  assign extB = {~strobe.useUnsigned & opB[DATA_W-1], opB};
  assign fullP = $signed(extA) * $signed(extB);
  assign prodNext = fullP[PROD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmpQ <= '0;
      prodQ <= '0;
      modeQ <= 2'b00;
    end else begin
      if (strobe.tmpLoad) tmpQ <= opData;
      if (strobe.modeLoad) modeQ <= opData[1:0];
      if (strobe.prodClear) prodQ <= '0;
      else if (strobe.prodLoad) prodQ <= prodNext;
      else if (strobe.prodHiLoad) prodQ[PROD_W-1:DATA_W] <= opData;
    end
  end

  mps_scaler #(
    .PROD_W(PROD_W), .SH_ONE(SH_ONE), .SH_FOUR(SH_FOUR), .SH_RIGHT(SH_RIGHT)
  ) scaler (
    .prodIn(prodQ),
    .mode(modeQ),
    .prodOut(prodScaled)
  );
endmodule

// File: rtl/mps_top.sv
module mps_top
  import mps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W = 13,
  parameter int SH_ONE = 1,
  parameter int SH_FOUR = 4,
  parameter int SH_RIGHT = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opCode,
  input  logic [DATA_W-1:0]   opData,
  output logic [DATA_W-1:0]   tmpReg,
  output logic [2*DATA_W-1:0] prodReg,
  output logic [1:0]          scaleMode,
  output logic [2*DATA_W-1:0] prodScaled
);
  mulStrobe_t strobe;

  mps_ctrl ctrl (
    .opValid(opValid),
    .opCode(opCode),
    .strobe(strobe)
  );

  mps_datapath #(
    .DATA_W(DATA_W), .IMM_W(IMM_W),
    .SH_ONE(SH_ONE), .SH_FOUR(SH_FOUR), .SH_RIGHT(SH_RIGHT)
  ) dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .opData(opData),
    .tmpQ(tmpReg),
    .prodQ(prodReg),
    .modeQ(scaleMode),
    .prodScaled(prodScaled)
  );
endmodule

// File: rtl/mps_chk.sv
module mps_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  opCode,
  input logic [15:0] opData,
  input logic [15:0] tmpReg,
  input logic [31:0] prodReg,
  input logic [1:0]  scaleMode,
  input logic [31:0] prodScaled
);
  // R2
  tmp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd1) |=> (tmpReg == $past(opData) && $stable(prodReg)));

  // R6
  imm_zero_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd5 && opData[12:0] == 13'd0) |=> (prodReg == 32'd0));

  // R7
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd6) |=>
      (prodReg[31:16] == $past(opData) && prodReg[15:0] == $past(prodReg[15:0])));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd7) |=> (prodReg == 32'd0));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode != 3'd0) |=> $stable(scaleMode));

  // R12
  right_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scaleMode == 2'b11) |-> (prodScaled[31:26] == {6{prodReg[31]}}));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(prodReg) && $stable(tmpReg) && $stable(scaleMode)));
endmodule

bind mps_top mps_chk chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opData(opData),
  .tmpReg(tmpReg), .prodReg(prodReg), .scaleMode(scaleMode), .prodScaled(prodScaled)
);

// File: tb/tb_mps_top.sv
module tb_mps_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] opData = 16'd0;
  logic [15:0] tmpReg;
  logic [31:0] prodReg;
  logic [1:0]  scaleMode;
  logic [31:0] prodScaled;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mps_top dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opData(opData),
    .tmpReg(tmpReg), .prodReg(prodReg), .scaleMode(scaleMode), .prodScaled(prodScaled)
  );

  // {opcode, operand register value, data word}
  localparam int NVEC = 8;
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd2, 16'h7FFF, 16'h8000},
    {3'd2, 16'hFFFD, 16'h0005},
    {3'd2, 16'h8000, 16'h8000},
    {3'd3, 16'hFFFF, 16'hFFFF},
    {3'd3, 16'h8000, 16'h0002},
    {3'd4, 16'h1234, 16'h8000},
    {3'd5, 16'h0100, 16'h1FFF},
    {3'd5, 16'hFFF0, 16'hE00F}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    opValid = 1'b1;
    opCode = op;
    opData = d;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  function automatic logic [31:0] model(input logic [2:0] op, input logic [15:0] t,
                                        input logic [15:0] d);
    logic [15:0] imm;
    imm = {{3{d[12]}}, d[12:0]};
    case (op)
      3'd2: return 32'($signed(t) * $signed(d));
      3'd3: return {16'd0, t} * {16'd0, d};
      3'd4: return 32'($signed(d) * $signed(d));
      3'd5: return 32'($signed(t) * $signed(imm));
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] scaleOf(input logic [31:0] p, input logic [1:0] m);
    case (m)
      2'd0: return p;
      2'd1: return {p[30:0], 1'b0};
      2'd2: return {p[27:0], 4'h0};
      default: return {{6{p[31]}}, p[31:6]};
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'd2: return "R11";
      2'd3: return "R12";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tmpReg == 16'd0, "R1 tmp", {16'd0, tmpReg}, 32'd0);
    check(prodReg == 32'd0, "R1 prod", prodReg, 32'd0);
    check(scaleMode == 2'd0, "R1 mode", {30'd0, scaleMode}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [15:0] t, d;
      {op, t, d} = VEC[i];
      doOp(3'd0, 16'd0);
      doOp(3'd1, t);
      check(tmpReg == t, "R2", {16'd0, tmpReg}, {16'd0, t});
      doOp(op, d);
      exp = model(op, t, d);
      check(prodReg == exp, tagOf(op), prodReg, exp);
      if (op == 3'd4) check(tmpReg == t, "R5 tmp kept", {16'd0, tmpReg}, {16'd0, t});
      for (int m = 0; m < 4; m++) begin
        doOp(3'd0, {14'h3FFF, 2'(m)});
        check(scaleMode == 2'(m), "R9", {30'd0, scaleMode}, m);
        check(prodScaled == scaleOf(exp, 2'(m)), modeTag(2'(m)), prodScaled,
              scaleOf(exp, 2'(m)));
        check(prodReg == exp, "R13 prod unscaled", prodReg, exp);
      end
    end

    // R9: non-mode opcodes keep the mode (currently 3)
    doOp(3'd1, 16'h0000);
    check(scaleMode == 2'd3, "R9 kept", {30'd0, scaleMode}, 32'd3);

    // R7: high half load keeps low half
    doOp(3'd1, 16'h0003);
    doOp(3'd2, 16'h1111);
    doOp(3'd6, 16'hABCD);
    check(prodReg == 32'hABCD3333, "R7", prodReg, 32'hABCD3333);

    // R8: clear
    doOp(3'd7, 16'h5555);
    check(prodReg == 32'd0, "R8", prodReg, 32'd0);

    // R6: immediate zero with upper data bits set clears product
    doOp(3'd1, 16'h1234);
    doOp(3'd2, 16'h0010);
    doOp(3'd5, 16'hE000);
    check(prodReg == 32'd0, "R6 zero imm", prodReg, 32'd0);

    // R6/R7: restore a saved product 0x5A5A_F00D
    doOp(3'd1, 16'hF00D);
    doOp(3'd5, 16'h0001);
    check(prodReg == 32'hFFFFF00D, "R6 times one", prodReg, 32'hFFFFF00D);
    doOp(3'd6, 16'h5A5A);
    check(prodReg == 32'h5A5AF00D, "R7 restore", prodReg, 32'h5A5AF00D);

    // R13: opValid low with an active-looking bus holds everything
    held = prodReg;
    @(negedge clk);
    opCode = 3'd7;
    opData = 16'h0002;
    repeat (3) @(negedge clk);
    check(prodReg == held, "R13 prod hold", prodReg, held);
    check(tmpReg == 16'hF00D, "R13 tmp hold", {16'd0, tmpReg}, 32'h0000F00D);
    check(scaleMode == 2'd3, "R13 mode hold", {30'd0, scaleMode}, 32'd3);

    // R1: reset in mid-stream
    rstN = 1'b0;
    @(negedge clk);
    check(prodReg == 32'd0 && tmpReg == 16'd0 && scaleMode == 2'd0, "R1 mid reset",
          prodReg, 32'd0);
    rstN = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule